// File: doc/BRIEF.md
# Execute-Stage Second Operand Former with Immediate Prefix

This block produces the second (B) operand for the execute stage of a 16-bit RISC pipeline. From the opcode in bits 15:12 of the instruction word it picks one of five sources:

- the value read from the register file;
- the 4-bit immediate in bits 3:0, sign-extended;
- the same field, zero-extended;
- the same field, doubled as a word displacement;
- the 12-bit field of a prefix instruction, with four zero bits below it.

A prefix instruction (opcode 0xD) supplies the upper twelve bits of a 16-bit constant. When the pipeline consumes a prefix, the block stores bits 11:0 of that instruction and raises a pending flag. The next immediate-using instruction then gets those stored bits placed above its own 4-bit field, in place of any extension or scaling. The pending flag is a port. Interrupt logic outside the block reads it so that it never splits a prefix from the instruction that follows it.

The operand is combinational from the current instruction word and the stored prefix state. The pending flag and the stored bits change only on a clock edge where the advance strobe is high.

Top module: `opb_former`

## Requirements
- R1: While reset (rst_n low) is asserted, and after it is released, the pending flag is 0.
- R2: Opcodes 0x0, 0x1, 0x3, 0x7, 0xB, 0xE and 0xF set the operand to the register value. This holds even when a prefix is pending.
- R3: With no prefix pending, opcodes 0x2 and 0x4 set the operand to bits 3:0 sign-extended to 16 bits (range -8..7).
- R4: With no prefix pending, opcodes 0x6 and 0x9 set the operand to bits 3:0 zero-extended (range 0..15).
- R5: With no prefix pending, opcodes 0x5, 0x8, 0xA and 0xC set the operand to bits 3:0 multiplied by two (0, 2..30).
- R6: Opcode 0xD (prefix) sets the operand to bits 11:0 followed by four zero bits, whether or not a prefix is pending.
- R7: On an advancing edge with opcode 0xD, the pending flag is set and bits 11:0 are stored. While the flag is set, every immediate opcode from R3, R4 and R5 gets the stored bits as operand bits 15:4 and its own bits 3:0 as operand bits 3:0.
- R8: On an advancing edge with any opcode other than 0xD, the pending flag is cleared. A second prefix in a row replaces the stored bits.
- R9: On an edge where the advance strobe is low, the pending flag and the stored bits keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn | input | 16 | Instruction word in the execute stage |
| regb | input | 16 | Register file value for the B operand |
| adv | input | 1 | High when the current instruction is consumed this cycle |
| opb | output | 16 | Formed B operand |
| pfx_pend | output | 1 | A prefix has been consumed and its follower has not |

## Verification
The checker tests the following on every cycle:

- the pending flag's set, clear and hold rules around the advance strobe;
- that register-format opcodes select the register value;
- the prefix instruction's own operand;
- the merge of stored bits into the instruction right after a consumed prefix.

The exact extension of each immediate class is shown only by the bench's vectors:

- the sign boundary at -8 and 7;
- the zero-extended 15;
- the doubled 30.

The bench's directed sequences also cover the cases that need more than one cycle to show:

- a prefix held across stalled cycles;
- a prefix replaced by a second prefix;
- a pending prefix cancelled by reset.

// File: rtl/opb_former.sv
module opb_former (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] insn,
  input  logic [15:0] regb,
  input  logic        adv,
  output logic [15:0] opb,
  output logic        pfx_pend
);

  localparam int W   = 16;
  localparam int IW  = 4;
  localparam int HW  = W - IW;
  localparam logic [3:0] OP_PFX = 4'hD;

  typedef enum logic [2:0] {SRC_REG, SRC_SX, SRC_ZX, SRC_WD, SRC_PFX} src_e;

  logic [3:0]    op;
  logic [IW-1:0] imm4;
  logic [HW-1:0] hi_q;
  src_e          src;

  assign op   = insn[15:12];
  assign imm4 = insn[IW-1:0];

  always_comb begin
    case (op)
      4'h2, 4'h4:               src = SRC_SX;
      4'h6, 4'h9:               src = SRC_ZX;
      4'h5, 4'h8, 4'hA, 4'hC:   src = SRC_WD;
      OP_PFX:                   src = SRC_PFX;
      default:                  src = SRC_REG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfx_pend <= 1'b0;
      hi_q     <= '0;
    end else if (adv) begin
      pfx_pend <= (op == OP_PFX);
      if (op == OP_PFX) hi_q <= insn[HW-1:0];
    end
  end

  always_comb begin
    case (src)
      SRC_REG: opb = regb;
      SRC_PFX: opb = {insn[HW-1:0], {IW{1'b0}}};
      default: begin
        if (pfx_pend)            opb = {hi_q, imm4};
        else if (src == SRC_SX)  opb = {{HW{imm4[IW-1]}}, imm4};
        else if (src == SRC_ZX)  opb = {{HW{1'b0}}, imm4};
        else                     opb = {{(HW-1){1'b0}}, imm4, 1'b0};
      end
    endcase
  end

endmodule

// File: rtl/opb_former_chk.sv
module opb_former_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] insn,
  input logic [15:0] regb,
  input logic        adv,
  input logic [15:0] opb,
  input logic        pfx_pend
);

  logic imm_op;
  assign imm_op = insn[15:12] inside {4'h2, 4'h4, 4'h5, 4'h6, 4'h8, 4'h9, 4'hA, 4'hC};

  p_regsel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (insn[15:12] inside {4'h0, 4'h1, 4'h3}) |-> opb == regb);

  p_pfx_operand_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (insn[15:12] == 4'hD) |-> opb[3:0] == 4'h0 && opb[15:4] == insn[11:0]);

  p_pend_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && insn[15:12] == 4'hD) |=> pfx_pend);

  p_merge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && insn[15:12] == 4'hD) |=> (!imm_op || (opb[15:4] == $past(insn[11:0]) && opb[3:0] == insn[3:0])));

  p_pend_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && insn[15:12] != 4'hD) |=> !pfx_pend);

  p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(pfx_pend));

endmodule

bind opb_former opb_former_chk u_chk (
  .clk(clk), .rst_n(rst_n), .insn(insn), .regb(regb),
  .adv(adv), .opb(opb), .pfx_pend(pfx_pend)
);

// File: tb/test_opb_former.sv
module test_opb_former;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] insn = 16'h0000;
  logic [15:0] regb = 16'h0000;
  logic        adv = 1'b0;
  logic [15:0] opb;
  logic        pfx_pend;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  opb_former i_opb_former (
    .clk(clk), .rst_n(rst_n), .insn(insn), .regb(regb),
    .adv(adv), .opb(opb), .pfx_pend(pfx_pend)
  );

  // {insn, regb, expected operand}, no prefix pending
  localparam int NV = 18;
  localparam logic [47:0] VEC [NV] = '{
    {16'h0123, 16'hBEEF, 16'hBEEF},  // R2
    {16'h1ABC, 16'h1234, 16'h1234},  // R2
    {16'h3D05, 16'h00FF, 16'h00FF},  // R2
    {16'hB0F3, 16'h5555, 16'h5555},  // R2
    {16'hF000, 16'hAAAA, 16'hAAAA},  // R2
    {16'h2127, 16'h9999, 16'h0007},  // R3
    {16'h2128, 16'h9999, 16'hFFF8},  // R3
    {16'h451F, 16'h0000, 16'hFFFF},  // R3
    {16'h6230, 16'hFFFF, 16'h0000},  // R4
    {16'h623F, 16'h0000, 16'h000F},  // R4
    {16'h9A1C, 16'h0000, 16'h000C},  // R4
    {16'h5317, 16'h0000, 16'h000E},  // R5
    {16'h8A1F, 16'h0000, 16'h001E},  // R5
    {16'hA021, 16'h0000, 16'h0002},  // R5
    {16'hC000, 16'hFFFF, 16'h0000},  // R5
    {16'hDABC, 16'h1111, 16'hABC0},  // R6
    {16'hD000, 16'h1111, 16'h0000},  // R6
    {16'h7F0F, 16'h0F0F, 16'h0F0F}   // R2
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] i, input logic [15:0] r, input logic a);
    @(negedge clk);
    insn = i; regb = r; adv = a;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", {15'b0, pfx_pend}, 16'h0000);
    rst_n = 1'b1;
    step(16'h0000, 16'h0000, 1'b0);
    chk("R1 after reset", {15'b0, pfx_pend}, 16'h0000);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k][47:32], VEC[k][31:16], 1'b0);
      chk("vector R2-R6 table", opb, VEC[k][15:0]);
      chk("R9 no pend", {15'b0, pfx_pend}, 16'h0000);
    end

    // R7: consume prefix, merge with signed follower
    step(16'hD123, 16'h0000, 1'b1);
    chk("R6 prefix operand", opb, 16'h1230);
    step(16'h2AB5, 16'h0000, 1'b1);
    chk("R7 pend set", {15'b0, pfx_pend}, 16'h0001);
    chk("R7 merge signed", opb, 16'h1235);
    step(16'h2AB5, 16'h0000, 1'b0);
    chk("R8 pend cleared", {15'b0, pfx_pend}, 16'h0000);
    chk("R8 follower back to sign ext", opb, 16'h0005);

    // R7: unsigned and scaled kinds take the stored bits unscaled
    step(16'hDFFF, 16'h0000, 1'b1);
    step(16'h6008, 16'h0000, 1'b0);
    chk("R7 merge unsigned", opb, 16'hFFF8);
    step(16'h5007, 16'h0000, 1'b1);
    chk("R7 merge scaled", opb, 16'hFFF7);

    // R8: second prefix replaces the first
    step(16'hD111, 16'h0000, 1'b1);
    step(16'hD222, 16'h0000, 1'b1);
    chk("R6 prefix while pending", opb, 16'h2220);
    step(16'h4003, 16'h0000, 1'b1);
    chk("R8 replaced prefix", opb, 16'h2223);

    // R9: stall holds flag and bits
    step(16'hD777, 16'h0000, 1'b1);
    step(16'h2001, 16'h0000, 1'b0);
    step(16'h2001, 16'h0000, 1'b0);
    step(16'hD999, 16'h0000, 1'b0);
    step(16'h2001, 16'h0000, 1'b0);
    chk("R9 pend held", {15'b0, pfx_pend}, 16'h0001);
    chk("R9 bits held", opb, 16'h7771);

    // R2: register opcode ignores pending prefix, then R8 clears
    step(16'h0123, 16'h4444, 1'b1);
    chk("R2 reg while pending", opb, 16'h4444);
    step(16'h2001, 16'h0000, 1'b0);
    chk("R8 cleared by reg op", {15'b0, pfx_pend}, 16'h0000);
    chk("R8 no stale merge", opb, 16'h0001);

    // R1: reset cancels a pending prefix
    step(16'hD555, 16'h0000, 1'b1);
    step(16'h2001, 16'h0000, 1'b0);
    chk("R7 pend before reset", {15'b0, pfx_pend}, 16'h0001);
    rst_n = 1'b0;
    #1;
    chk("R1 reset clears pend", {15'b0, pfx_pend}, 16'h0000);
    step(16'h2001, 16'h0000, 1'b0);
    rst_n = 1'b1;
    step(16'h2001, 16'h0000, 1'b0);
    chk("R1 sign ext after reset", opb, 16'h0001);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule